// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

The block holds a small queue of stereo sample pairs and sends them one bit at a time on a single serial data line. An outside clock source supplies two strobes. `bit_tick` marks the active edge of each bit period. `frame_sync` comes together with the tick that opens a new frame. Each frame carries two channel slots, left first and then right. Runtime fields set the slot length (16, 32 or 64 bits) and the word length (16, 24 or 32 bits). Two flags set where the word sits inside its slot: a one-bit first-bit delay for classic I2S timing, and right alignment.

Samples arrive as 32-bit values with the word right-aligned, so a 16-bit word uses bits 15:0. Bits are sent MSB first and all padding is zero. A pair is taken from the queue only at a frame start, so the two channels cannot swap. If the queue is empty when a frame starts while the transmitter is enabled, the whole frame is silent and a sticky underrun flag is set.

Top module: `stereo_ser_tx`

## Requirements
- R1: Word-length code `cfg_wlen` 0, 1 and 2 selects 16, 24 and 32 bits (code 3 acts as 32). The word is taken from the low bits of the 32-bit sample and sent MSB first.
- R2: With `cfg_delay`=1 and `cfg_rjust`=0, the word MSB occupies slot position 1 and position 0 is zero. With `cfg_delay`=0, the MSB occupies position 0.
- R3: With `cfg_rjust`=1, the word LSB occupies the last position of the slot, zeros fill the positions before the word, and `cfg_delay` is ignored.
- R4: Slot-length code `cfg_slot` 0, 1 and 2 selects S = 16, 32 and 64 bits (code 3 acts as 64). Frame bit p (0 at the `frame_sync` tick) belongs to the left slot for p < S and to the right slot, at position p-S, for S ≤ p < 2S. Positions not holding word bits carry 0.
- R5: A word longer than the bits available in its slot is truncated, keeping its MSBs. S bits are available with right alignment, S-1 with the first-bit delay, and S otherwise.
- R6: While `tx_en`=0, every bit sent is 0, no pair is taken from the queue and the underrun flag is not set.
- R7: One pair is removed from the queue at each `frame_sync` tick that has `tx_en`=1 and a non-empty queue, and at no other time. That pair supplies both slots of the frame.
- R8: A `frame_sync` tick with `tx_en`=1 and an empty queue sends zeros for the whole frame and sets `underrun`. The flag stays set until a cycle with `clr_underrun`=1. If both happen in the same cycle, setting wins.
- R9: `fifo_full` is high when FIFO_DEPTH pairs are held. A write while full is dropped. `fifo_empty` is high when no pair is held.
- R10: After reset, `sdata`=0, `fifo_empty`=1, `fifo_full`=0 and `underrun`=0. Bits before the first `frame_sync` tick, and frame bits at p ≥ 2S, are 0.
- R11: `sdata` is registered. It takes the value for a tick in the clock cycle after that tick and holds it until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one stereo pair into the queue |
| wr_left | input | 32 | Left sample, word right-aligned |
| wr_right | input | 32 | Right sample, word right-aligned |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| frame_sync | input | 1 | With bit_tick: this bit opens a frame |
| tx_en | input | 1 | Transmit enable |
| cfg_delay | input | 1 | First-bit delay (I2S timing) |
| cfg_rjust | input | 1 | Right alignment, takes precedence over delay |
| cfg_wlen | input | 2 | Word-length code |
| cfg_slot | input | 2 | Slot-length code |
| clr_underrun | input | 1 | Clears the underrun flag |
| sdata | output | 1 | Serial data line |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with the default FIFO_DEPTH of 4. Four writes therefore reach the full state, and a fifth write tests the drop rule. All slot and word lengths are runtime fields, so one build covers every placement: left-justified, delayed, right-aligned, and truncated when a 32-bit word meets a 16-bit slot. Random frames mix these settings with queue levels that go down to empty, which makes underruns and disabled frames happen next to normal ones.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SAMPLE_W = 32;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    // slot length in bits from its code
    function automatic logic [6:0] slot_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 7'd16;
            2'd1:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    // word length in bits from its code
    function automatic logic [5:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd16;
            2'd1:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);
    assign dout  = mem[ptr_q.rp];

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            ptr_d.wp = (ptr_q.wp == AW'(DEPTH - 1)) ? '0 : ptr_q.wp + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rp = (ptr_q.rp == AW'(DEPTH - 1)) ? '0 : ptr_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp] <= din;
    end

endmodule

// File: rtl/stx_slot_pick.sv
module stx_slot_pick #(
    parameter int SW = 32
) (
    input  logic [5:0]    pos,      // position inside the slot
    input  logic [6:0]    slot_len,
    input  logic [5:0]    wlen,
    input  logic          delay,
    input  logic          rjust,
    input  logic [SW-1:0] word,
    output logic          bit_out
);
    logic [6:0] avail, eff, start, off, p7;
    logic [4:0] idx;
    logic       hit;

    always_comb begin
        p7    = {1'b0, pos};
        // right alignment overrides the first-bit delay
        avail = rjust ? slot_len : slot_len - {6'b0, delay};
        eff   = ({1'b0, wlen} < avail) ? {1'b0, wlen} : avail;
        start = rjust ? slot_len - eff : {6'b0, delay};
        off   = p7 - start;
        hit   = (p7 >= start) && (off < eff);
        idx   = 5'({1'b0, wlen} - 7'd1 - off);
        bit_out = hit && word[idx];
    end

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_left,
    input  logic [31:0] wr_right,
    input  logic        bit_tick,
    input  logic        frame_sync,
    input  logic        tx_en,
    input  logic        cfg_delay,
    input  logic        cfg_rjust,
    input  logic [1:0]  cfg_wlen,
    input  logic [1:0]  cfg_slot,
    input  logic        clr_underrun,
    output logic        sdata,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic        underrun
);
    import stx_pkg::*;

    localparam int FRAME_MAX = 128;
    localparam int POS_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             framed;
        pair_t            cur;
        logic             sdata;
        logic             underrun;
    } st_t;

    st_t   st_d, st_q;
    pair_t head, pair_now;
    logic  pop;
    logic  [POS_W-1:0] pos_now, pos_rel;
    logic  [6:0] slot_len;
    logic  [5:0] wlen, slot_pos;
    logic  right_ch, in_frame, pick_bit;
    logic  [SAMPLE_W-1:0] word_now;

    stx_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(pair_t))) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   ({wr_left, wr_right}),
        .pop   (pop),
        .dout  (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // position and sample feeding the bit picker
    always_comb begin
        slot_len = slot_bits(cfg_slot);
        wlen     = word_bits(cfg_wlen);
        pos_now  = frame_sync ? '0 : st_q.pos;
        if (frame_sync) pair_now = (tx_en && !fifo_empty) ? head : '0;
        else            pair_now = st_q.cur;
        right_ch = (pos_now >= POS_W'(slot_len));
        in_frame = (pos_now < POS_W'({slot_len, 1'b0}));
        pos_rel  = right_ch ? pos_now - POS_W'(slot_len) : pos_now;
        slot_pos = 6'(pos_rel);
        word_now = right_ch ? pair_now.right : pair_now.left;
    end

    stx_slot_pick #(.SW(SAMPLE_W)) u_pick (
        .pos      (slot_pos),
        .slot_len (slot_len),
        .wlen     (wlen),
        .delay    (cfg_delay),
        .rjust    (cfg_rjust),
        .word     (word_now),
        .bit_out  (pick_bit)
    );

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (clr_underrun) st_d.underrun = 1'b0;
        if (bit_tick) begin
            if (frame_sync) begin
                st_d.framed = 1'b1;
                st_d.cur    = pair_now;
                if (tx_en) begin
                    if (!fifo_empty) pop = 1'b1;
                    else             st_d.underrun = 1'b1;
                end
            end
            st_d.pos   = (pos_now == '1) ? pos_now : pos_now + 1'b1;
            st_d.sdata = tx_en && (frame_sync || st_q.framed) && in_frame && pick_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdata    = st_q.sdata;
    assign underrun = st_q.underrun;

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic bit_tick,
    input logic frame_sync,
    input logic tx_en,
    input logic clr_underrun,
    input logic sdata,
    input logic fifo_full,
    input logic fifo_empty,
    input logic underrun
);
    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(sdata));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !tx_en) |=> !sdata);

    assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(bit_tick && frame_sync && tx_en && fifo_empty));

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_underrun) |=> underrun);

    assert_full_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !(bit_tick && frame_sync)) |=> fifo_full);

    assert_pop_only_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bit_tick && frame_sync) && !wr_en) |=> $stable(fifo_empty));
endmodule

bind stereo_ser_tx stx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .bit_tick     (bit_tick),
    .frame_sync   (frame_sync),
    .tx_en        (tx_en),
    .clr_underrun (clr_underrun),
    .sdata        (sdata),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .underrun     (underrun)
);

// File: tb/tb_stereo_ser_tx.sv
module tb_stereo_ser_tx;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_left = '0, wr_right = '0;
    logic bit_tick = 1'b0, frame_sync = 1'b0, tx_en = 1'b0;
    logic cfg_delay = 1'b0, cfg_rjust = 1'b0;
    logic [1:0] cfg_wlen = '0, cfg_slot = '0;
    logic clr_underrun = 1'b0;
    logic sdata, fifo_full, fifo_empty, underrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit exp_unr = 0;
    logic [63:0] mq[$];

    always #5 clk = ~clk;

    stereo_ser_tx #(.FIFO_DEPTH(DEPTH)) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        return (c == 0) ? 16 : (c == 1) ? 24 : 32;
    endfunction
    function automatic int sbits(input logic [1:0] c);
        return (c == 0) ? 16 : (c == 1) ? 32 : 64;
    endfunction

    // expected slot contents, bit i = slot position i
    function automatic logic [63:0] exp_slot(input logic [31:0] w, input bit d,
                                             input bit rj, input int wl, input int s);
        logic [63:0] v;
        int avail, eff;
        v = '0;
        avail = rj ? s : s - int'(d);
        eff = (wl < avail) ? wl : avail;
        for (int i = 0; i < eff; i++) begin
            if (rj) v[s-1-i] = w[wl-eff+i];
            else    v[int'(d)+i] = w[wl-1-i];
        end
        return v;
    endfunction

    task automatic push(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_left = l; wr_right = r;
        @(negedge clk);
        wr_en = 1'b0;
        if (mq.size() < DEPTH) mq.push_back({l, r});
    endtask

    task automatic flags(input string req);
        check(fifo_empty == (mq.size() == 0), req, "fifo_empty", fifo_empty, mq.size() == 0);
        check(fifo_full == (mq.size() == DEPTH), req, "fifo_full", fifo_full, mq.size() == DEPTH);
        check(underrun == exp_unr, req, "underrun", underrun, exp_unr);
    endtask

    // one bit period; returns sdata after the tick, checks it holds one more cycle
    task automatic tick(input bit sync, output logic v, output bit stable);
        @(negedge clk);
        bit_tick = 1'b1; frame_sync = sync;
        @(negedge clk);
        bit_tick = 1'b0; frame_sync = 1'b0;
        v = sdata;
        @(negedge clk);
        stable = (sdata == v);
    endtask

    task automatic run_frame(input bit d, input bit rj, input logic [1:0] wc,
                             input logic [1:0] sc, input bit en, input int extra,
                             input string req);
        logic [63:0] pr, el, er, got, exp;
        int s, wl, bad, unstable;
        logic v;
        bit st;
        @(negedge clk);
        cfg_delay = d; cfg_rjust = rj; cfg_wlen = wc; cfg_slot = sc; tx_en = en;
        s = sbits(sc); wl = wbits(wc);
        pr = '0;
        if (en) begin
            if (mq.size() > 0) pr = mq.pop_front();
            else exp_unr = 1;
        end
        el = exp_slot(pr[63:32], d, rj, wl, s);
        er = exp_slot(pr[31:0], d, rj, wl, s);
        bad = 0; unstable = 0; got = '0; exp = '0;
        for (int p = 0; p < 2 * s + extra; p++) begin
            logic e;
            tick(p == 0, v, st);
            if (p < s) e = el[p];
            else if (p < 2 * s) e = er[p - s];
            else e = 1'b0;
            if (v !== e) begin
                if (bad == 0) begin got = 64'(p); exp = 64'(e); end
                bad++;
            end
            if (!st) unstable++;
        end
        check(bad == 0, req, "frame bit mismatch first_pos/expected_bit", got, exp);
        check(unstable == 0, "R11", "sdata changed between ticks", unstable, 0);
        flags(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v;
        bit st;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(sdata == 0, "R10", "reset sdata", sdata, 0);
        flags("R10");

        // R10 bits before the first frame start are zero, nothing popped (R7)
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        tx_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, v, st);
            check(v == 0, "R10", "pre-frame bit", v, 0);
        end
        flags("R7");

        // R2 I2S delay, R5 32-bit word in 32-bit slot truncated to 31 bits
        push(32'h8000_0001, 32'hC000_0003);
        run_frame(1, 0, 2'd2, 2'd1, 1, 0, "R2");
        run_frame(1, 0, 2'd2, 2'd1, 1, 0, "R5");
        // R2 left-justified 16 in 32, R1 word codes
        push(32'hABCD_8421, 32'h1234_F00F);
        run_frame(0, 0, 2'd0, 2'd1, 1, 0, "R2");
        push(32'h00A5_5A3C, 32'hFF80_0001);
        run_frame(0, 0, 2'd1, 2'd1, 1, 0, "R1");
        // R3 right-justified 24 in 32, delay ignored
        push(32'h12F0_0F81, 32'h0081_8181);
        run_frame(1, 1, 2'd1, 2'd1, 1, 0, "R3");
        // R5 32-bit word right-justified into 16-bit slot
        push(32'hDEAD_BEEF, 32'h8765_4321);
        run_frame(0, 1, 2'd2, 2'd0, 1, 0, "R5");
        // R4 64-bit slot, with extra bits past the frame end (R10)
        push(32'hF0F0_1111, 32'h0F0F_8888);
        run_frame(1, 0, 2'd2, 2'd2, 1, 6, "R4");
        push(32'h0000_FFFF, 32'h0000_8001);
        run_frame(0, 1, 2'd0, 2'd2, 1, 5, "R10");

        // R6 disabled frame: zeros, no pop, no underrun
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_frame(0, 0, 2'd2, 2'd1, 0, 0, "R6");
        run_frame(0, 0, 2'd2, 2'd1, 1, 0, "R7");
        run_frame(0, 0, 2'd2, 2'd1, 0, 0, "R6");

        // R8 underrun on empty queue, sticky, then cleared
        run_frame(0, 0, 2'd2, 2'd0, 1, 0, "R8");
        run_frame(0, 0, 2'd2, 2'd0, 0, 0, "R8");
        @(negedge clk); clr_underrun = 1'b1;
        @(negedge clk); clr_underrun = 1'b0; exp_unr = 0;
        flags("R8");

        // R9 fill past full, extra write dropped
        for (int i = 0; i < DEPTH + 1; i++) push(32'h1111_0000 * (i + 1), ~(32'h0101_0101 * i));
        flags("R9");
        for (int i = 0; i < DEPTH; i++) run_frame(i[0], 0, 2'd2, 2'd1, 1, 0, "R9");
        run_frame(0, 0, 2'd2, 2'd1, 1, 0, "R8");
        // R8 set wins over simultaneous clear
        @(negedge clk); clr_underrun = 1'b1;
        @(negedge clk); clr_underrun = 1'b0; exp_unr = 0;
        @(negedge clk);
        tx_en = 1'b1; clr_underrun = 1'b1; bit_tick = 1'b1; frame_sync = 1'b1;
        @(negedge clk);
        clr_underrun = 1'b0; bit_tick = 1'b0; frame_sync = 1'b0; exp_unr = 1;
        check(underrun == 1, "R8", "set wins over clear", underrun, 1);

        // random frames
        for (int f = 0; f < 30; f++) begin
            int n;
            n = $urandom_range(0, 2);
            for (int k = 0; k < n; k++) push($urandom, $urandom);
            run_frame(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                      ($urandom_range(0, 5) != 0), $urandom_range(0, 3), "R4");
            if (exp_unr && $urandom_range(0, 1) == 1) begin
                @(negedge clk); clr_underrun = 1'b1;
                @(negedge clk); clr_underrun = 1'b0; exp_unr = 0;
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule